// File: doc/BRIEF.md
# Second-Order Recursive Filter Core

This core is a fixed-point biquad filter in direct form I. Each time the sample strobe is high it accepts one signed 16-bit input word in pure-fractional Q1.15 format. It combines that word with the two previous inputs and the two previous outputs, using five coefficients fixed at elaboration time. One clock later it presents one signed 16-bit result in Q5.11 format, with four integer bits of headroom.

All five products are kept at full precision and summed in a wide accumulator that cannot overflow. The sum is then scaled down to the output format by an arithmetic right shift, which rounds toward minus infinity. Values outside the 16-bit range are clamped. The feedback path stores the clamped result, so the recursion follows exactly what leaves the block. Coefficients are signed Q2.14 values, so each magnitude must be below 2.

Top module: `iir_biquad_core`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all four history registers, `y_out` and `valid_out` become zero at that edge, even when `valid_in` is high.
- R2: `valid_out` is high in the cycle after each cycle in which `valid_in` was sampled high out of reset, and low in every other cycle.
- R3: For each accepted sample, `y_out` equals floor((B0·x[n] + B1·x[n-1] + B2·x[n-2] − 16·(A1·y[n-1] + A2·y[n-2])) / 2^18). Here x is the Q1.15 integer code, y is the Q5.11 integer code and the coefficients are Q2.14 integer codes. This holds for results inside the 16-bit range.
- R4: A result above 32767 is output as 16'h7FFF.
- R5: A result below −32768 is output as 16'h8000.
- R6: The y history holds the clamped output value, so later samples use the value that was actually emitted.
- R7: In cycles where `valid_in` is low, `x_in` is ignored: `y_out` and the history stay unchanged, and the next accepted sample uses the history from before the idle cycles.
- R8: Samples presented on consecutive cycles, with `valid_in` held high, are each filtered correctly with no gap.
- R9: After a reset in the middle of a stream, the filter answers exactly as a fresh filter would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Sample strobe; `x_in` is taken when high |
| x_in | input | 16 | Input sample, signed Q1.15 |
| valid_out | output | 1 | High for one cycle when a new result is on `y_out` |
| y_out | output | 16 | Filtered sample, signed Q5.11, held between strobes |

## Verification
Two functions can fall in the same cycle: clamping of the sum, and write-back of that result into the feedback history. The default coefficients place both poles close to z = 1, which gives a DC gain near 20. A long full-scale positive or negative run therefore drives the sum past the output range while the feedback keeps recirculating the clamped value. Each output is compared with a bench model that clamps before storing its own history. Any divergence after the first clamped sample shows that the wrong value was fed back. A reset asserted together with a strobe is also tried, to confirm that reset wins.

// File: rtl/iir_pkg.sv
// Package: iir_pkg
// Shared sample format constants and helper types for the biquad core.
// Assumes 16-bit signed samples on both sides of the filter.
package iir_pkg;
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int X_FRAC   = 15;   // Q1.15 input
    localparam int Y_FRAC   = 11;   // Q5.11 output
    localparam int C_FRAC   = 14;   // Q2.14 coefficients

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
endpackage

// File: rtl/iir_history.sv
// Module: iir_history
// Tapped shift register holding the most recent DEPTH accepted words.
// Tap 0 is the newest word. It shifts only when en is high and clears on
// a synchronous active-low reset. Assumes DEPTH >= 1.
module iir_history #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [W-1:0]         din,
    output logic [DEPTH*W-1:0]   taps
);
    logic [W-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Capture the newest word into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage[0] <= '0;
                else if (en) stage[0] <= din;
            end
        end else begin : g_body
            // Move the older word one stage further along.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage[i] <= '0;
                else if (en) stage[i] <= stage[i-1];
            end
        end
        assign taps[i*W +: W] = stage[i];
    end
endmodule

// File: rtl/iir_mac.sv
// Module: iir_mac
// Combinational weighted sum of the direct-form-I recursion.
// Feedforward products (Q1.15 x Q2.14) carry X_FRAC+C_FRAC fraction bits.
// Feedback products (Q5.11 x Q2.14) are shifted left by X_FRAC-Y_FRAC so that
// both kinds share one binary point. The accumulator is sized with guard
// bits so that the sum of all products cannot overflow.
module iir_mac
    import iir_pkg::*;
#(
    parameter int    ACC_W = 40,
    parameter coef_t B0 = 16'sh1000,
    parameter coef_t B1 = 16'sh2000,
    parameter coef_t B2 = 16'sh1000,
    parameter coef_t A1 = -16'sd31130,
    parameter coef_t A2 = 16'sd15565
) (
    input  sample_t                     x_cur,
    input  logic [2*SAMPLE_W-1:0]       x_taps,
    input  logic [2*SAMPLE_W-1:0]       y_taps,
    output logic signed [ACC_W-1:0]     acc
);
    localparam int N_FF     = 3;
    localparam int N_FB     = 2;
    localparam int FB_SHIFT = X_FRAC - Y_FRAC;

    localparam coef_t FF_COEF [N_FF] = '{B0, B1, B2};
    localparam coef_t FB_COEF [N_FB] = '{A1, A2};

    sample_t ff_data [N_FF];
    logic signed [ACC_W-1:0] ff_prod [N_FF];
    logic signed [ACC_W-1:0] fb_prod [N_FB];

    assign ff_data[0] = x_cur;
    assign ff_data[1] = sample_t'(x_taps[0 +: SAMPLE_W]);
    assign ff_data[2] = sample_t'(x_taps[SAMPLE_W +: SAMPLE_W]);

    for (genvar i = 0; i < N_FF; i++) begin : g_ff
        logic signed [ACC_W-1:0] c_ext, d_ext;
        assign c_ext      = ACC_W'(FF_COEF[i]);
        assign d_ext      = ACC_W'(ff_data[i]);
        assign ff_prod[i] = c_ext * d_ext;
    end

    for (genvar j = 0; j < N_FB; j++) begin : g_fb
        logic signed [ACC_W-1:0] c_ext, d_ext;
        assign c_ext      = ACC_W'(FB_COEF[j]);
        assign d_ext      = ACC_W'(sample_t'(y_taps[j*SAMPLE_W +: SAMPLE_W]));
        assign fb_prod[j] = (c_ext * d_ext) <<< FB_SHIFT;
    end

    // Add the feedforward terms and subtract the feedback terms.
    always_comb begin
        acc = '0;
        for (int i = 0; i < N_FF; i++) acc = acc + ff_prod[i];
        for (int j = 0; j < N_FB; j++) acc = acc - fb_prod[j];
    end
endmodule

// File: rtl/iir_requant.sv
// Module: iir_requant
// Rescales the accumulator from X_FRAC+C_FRAC fraction bits to the Q5.11
// output by an arithmetic right shift (rounding toward minus infinity), then
// clamps the value to the signed SAMPLE_W range instead of wrapping.
module iir_requant
    import iir_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic signed [ACC_W-1:0] acc,
    output sample_t                 y_sat
);
    localparam int OUT_SHIFT = X_FRAC + C_FRAC - Y_FRAC;
    localparam logic signed [ACC_W-1:0] SAT_HI =
        ACC_W'((64'sd1 <<< (SAMPLE_W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    logic signed [ACC_W-1:0] scaled;

    assign scaled = acc >>> OUT_SHIFT;

    // Clamp the scaled sum to the representable output range.
    always_comb begin
        if (scaled > SAT_HI)      y_sat = sample_t'(SAT_HI);
        else if (scaled < SAT_LO) y_sat = sample_t'(SAT_LO);
        else                      y_sat = sample_t'(scaled);
    end
endmodule

// File: rtl/iir_biquad_core.sv
// Module: iir_biquad_core
// Direct-form-I biquad: Q1.15 samples in, Q5.11 samples out, with constant
// Q2.14 coefficients. The result registers one clock after valid_in, and the
// histories advance only on valid_in. The y history stores the clamped
// result. Reset is synchronous and active low, and wins over valid_in.
module iir_biquad_core
    import iir_pkg::*;
#(
    parameter coef_t B0 = 16'sh1000,
    parameter coef_t B1 = 16'sh2000,
    parameter coef_t B2 = 16'sh1000,
    parameter coef_t A1 = -16'sd31130,
    parameter coef_t A2 = 16'sd15565,
    parameter int    GUARD_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [15:0]         x_in,
    output logic                valid_out,
    output logic [15:0]         y_out
);
    localparam int HIST_DEPTH = 2;
    localparam int PROD_W     = SAMPLE_W + COEF_W;
    localparam int ACC_W      = PROD_W + (X_FRAC - Y_FRAC) + GUARD_BITS;

    logic [HIST_DEPTH*SAMPLE_W-1:0] x_taps;
    logic [HIST_DEPTH*SAMPLE_W-1:0] y_taps;
    logic signed [ACC_W-1:0]        acc;
    sample_t                        y_sat;
    logic [15:0]                    y_d1;

    iir_history #(.W(SAMPLE_W), .DEPTH(HIST_DEPTH)) u_xhist (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (valid_in),
        .din   (x_in),
        .taps  (x_taps)
    );

    iir_history #(.W(SAMPLE_W), .DEPTH(HIST_DEPTH)) u_yhist (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (valid_in),
        .din   (y_sat),
        .taps  (y_taps)
    );

    iir_mac #(
        .ACC_W (ACC_W),
        .B0 (B0), .B1 (B1), .B2 (B2), .A1 (A1), .A2 (A2)
    ) u_mac (
        .x_cur  (sample_t'(x_in)),
        .x_taps (x_taps),
        .y_taps (y_taps),
        .acc    (acc)
    );

    iir_requant #(.ACC_W(ACC_W)) u_requant (
        .acc   (acc),
        .y_sat (y_sat)
    );

    assign y_d1 = y_taps[0 +: SAMPLE_W];

    // Register the result and its strobe one clock after an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            y_out     <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) y_out <= y_sat;
        end
    end
endmodule

// File: rtl/iir_biquad_checker.sv
// Module: iir_biquad_checker
// Protocol and state properties for iir_biquad_core, attached by bind.
module iir_biquad_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_in,
    input logic        valid_out,
    input logic [15:0] y_out,
    input logic [15:0] y_hist0
);
    logic rst_seen_low;

    // Remember whether reset was low at the previous edge.
    always_ff @(posedge clk) rst_seen_low <= !rst_n;

    // R1: the edge after a low reset leaves the outputs cleared.
    always_ff @(posedge clk) begin
        if (rst_n && rst_seen_low)
            assert_reset_clear_R1: assert (y_out == 16'h0000 && !valid_out);
    end

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(y_out));

    assert_fb_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (y_hist0 == y_out));
endmodule

bind iir_biquad_core iir_biquad_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .valid_out (valid_out),
    .y_out     (y_out),
    .y_hist0   (y_d1)
);

// File: tb/iir_biquad_core_test.sv
`timescale 1ns/1ps
module iir_biquad_core_test;
    localparam logic signed [15:0] CB0 = 16'sh1000;
    localparam logic signed [15:0] CB1 = 16'sh2000;
    localparam logic signed [15:0] CB2 = 16'sh1000;
    localparam logic signed [15:0] CA1 = -16'sd31130;
    localparam logic signed [15:0] CA2 = 16'sd15565;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] x_in = '0;
    logic        valid_out;
    logic [15:0] y_out;

    int checks = 0;
    int failures = 0;
    longint mx1, mx2, my1, my2;

    always #4 clk = ~clk;

    iir_biquad_core #(.B0(CB0), .B1(CB1), .B2(CB2), .A1(CA1), .A2(CA2)) uut (
        .clk (clk), .rst_n (rst_n), .valid_in (valid_in), .x_in (x_in),
        .valid_out (valid_out), .y_out (y_out)
    );

    function automatic longint model_y(longint x);
        longint s;
        s = longint'(CB0) * x + longint'(CB1) * mx1 + longint'(CB2) * mx2
          - ((longint'(CA1) * my1 + longint'(CA2) * my2) <<< 4);
        s = s >>> 18;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    // Present one sample at a falling edge and check the result one clock later.
    task automatic send(input logic signed [15:0] x, input string req, output longint got);
        longint exp;
        exp = model_y(longint'(x));
        valid_in = 1'b1;
        x_in = x;
        @(negedge clk);
        check(valid_out == 1'b1, "R2", valid_out, 1);
        check(longint'($signed(y_out)) == exp, req, $signed(y_out), exp);
        got = longint'($signed(y_out));
        mx2 = mx1; mx1 = longint'(x);
        my2 = my1; my1 = exp;
    endtask

    task automatic go_idle();
        valid_in = 1'b0;
        @(negedge clk);
        check(valid_out == 1'b0, "R2", valid_out, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        valid_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic t_reset_state();
        check(valid_out == 1'b0, "R1", valid_out, 0);
        check(y_out == 16'h0000, "R1", y_out, 0);
    endtask

    task automatic t_impulse();
        longint g;
        send(16'sh4000, "R3", g);
        for (int i = 0; i < 10; i++) send(16'sh0000, "R3", g);
        go_idle();
    endtask

    task automatic t_idle_ignore();
        longint g;
        logic [15:0] held;
        send(16'sh2345, "R3", g);
        send(-16'sh1200, "R3", g);
        valid_in = 1'b0;
        held = y_out;
        for (int i = 0; i < 5; i++) begin
            x_in = 16'h7000 + 16'(i * 311);
            @(negedge clk);
            check(y_out == held, "R7", y_out, held);
            check(valid_out == 1'b0, "R7", valid_out, 0);
        end
        send(16'sh0100, "R7", g);
        go_idle();
    endtask

    task automatic t_stream();
        longint g;
        for (int i = 0; i < 40; i++) begin
            logic signed [15:0] v;
            v = 16'((i * 9173) % 40000 - 20000);
            send(v, "R8", g);
        end
        go_idle();
    endtask

    task automatic t_sat_pos();
        longint g;
        int hits = 0;
        do_reset();
        for (int i = 0; i < 90; i++) begin
            send(16'sh7FFF, "R6", g);
            if (g == 32767) hits++;
        end
        check(hits > 0, "R4", hits, 1);
        go_idle();
    endtask

    task automatic t_sat_neg();
        longint g;
        int hits = 0;
        do_reset();
        for (int i = 0; i < 90; i++) begin
            send(16'sh8000, "R6", g);
            if (g == -32768) hits++;
        end
        check(hits > 0, "R5", hits, 1);
        go_idle();
    endtask

    task automatic t_reset_midstream();
        longint g;
        send(16'sh3000, "R3", g);
        send(16'sh5000, "R3", g);
        rst_n = 1'b0;
        valid_in = 1'b1;
        x_in = 16'sh7777;
        @(negedge clk);
        check(valid_out == 1'b0, "R1", valid_out, 0);
        check(y_out == 16'h0000, "R1", y_out, 0);
        rst_n = 1'b1;
        valid_in = 1'b0;
        model_clear();
        send(16'sh4000, "R9", g);
        send(16'sh0000, "R9", g);
        send(16'sh0000, "R9", g);
        go_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_impulse();
        t_idle_ignore();
        t_stream();
        t_sat_pos();
        t_sat_neg();
        t_reset_midstream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule